// File: doc/BRIEF.md
# Square-Wave Phase Comparison Logic

This block makes the internal-fault decision for one compared current in a current-only pilot protection scheme. A sign bit of the local current, sampled on a 0.1 ms tick, is held back by a programmable digital delay equal to the channel latency. It is then compared with the polarity bit received from the far terminal. Because the delay is a shifted bit stream, the local pulse train keeps its exact high and low widths whatever the waveform or system frequency.

Two coincidence paths run side by side. The positive path looks for both squares high. The negative path inverts the received bit and looks for both squares low. Each path has a timer that must see an unbroken run of coincident samples before it raises its flag. Either flag raises a trip request while the enable is high, and the request then holds.

One instance serves one compared current. Two-current and per-phase arrangements use several instances side by side.

Top module: `sqwave_phase_cmp`

## Requirements
- R1: The delayed local polarity used at a tick equals the local polarity sampled exactly D ticks earlier, where D is the effective delay setting in ticks (one tick is 0.1 ms).
- R2: A local pulse lasting W ticks appears on the delayed stream as a pulse of exactly W ticks. With the received bit held at 1 and PICKUP = 40, a 40-tick pulse gives a positive flag lasting exactly one tick interval, and a 39-tick pulse gives no flag.
- R3: `coinc_pos` rises after the tick that completes PICKUP (40) consecutive ticks with the delayed local bit at 1 and `rcv_pol` at 1. It falls at the first tick where that condition fails. Between ticks, and when there is no flush, it does not change.
- R4: `coinc_neg` follows the same rule with the delayed local bit at 0 and `rcv_pol` at 0, the received bit being inverted before gating. `coinc_pos` and `coinc_neg` are never high together.
- R5: `trip` rises one clock after `coinc_pos` or `coinc_neg` is high while `enable` is 1. `trip` never rises unless a flag is high.
- R6: Once high, `trip` stays high while `enable` is 1, including across a change of the delay setting. It goes low on the clock after `enable` is 0.
- R7: A change of the effective delay setting clears both flags on the next clock. It also empties the delay history, so no coincidence is counted until D new samples have been taken. With both polarity bits held at a coincident level, the flag therefore rises at the (D+40)-th tick after the flush.
- R8: `dly_set` is clamped to the range 20 to 200 ticks. A value of 5 acts as 20 and a value of 250 acts as 200.
- R9: While `rst_n` is low, `coinc_pos`, `coinc_neg` and `trip` are 0, and reset flushes the delay history as in R7.
- R10: Square waves whose positive and negative overlaps are each shorter than 40 ticks never trip. Waves in exact anti-phase after the delay never trip.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-clock sample strobe, one per 0.1 ms |
| loc_pol | input | 1 | Local current polarity, 1 = positive |
| rcv_pol | input | 1 | Polarity received over the channel, 1 = positive |
| dly_set | input | 8 | Requested local delay in ticks, clamped to 20..200 |
| enable | input | 1 | Allows and holds the trip request |
| coinc_pos | output | 1 | Positive half-cycle coincidence timer has picked up |
| coinc_neg | output | 1 | Negative half-cycle coincidence timer has picked up |
| trip | output | 1 | Latched trip request |

## Verification
The bound assertions watch, on every cycle, the rules that relate ports and the internal flush over one or two clocks. These cover flags moving only on a tick or a flush, the two flags never overlapping, the flush clearing both flags, the trip latch being held, and trip dropping when `enable` is low. The exact delay count, the preserved pulse width, the clamp limits, the pickup instant after a flush, and the trip and no-trip outcome for given phase offsets and duty ratios all need long driven waveforms. Only the bench scenarios can show those.

// File: rtl/phc_pkg.sv
package phc_pkg;
    // Which half-cycle a coincidence timer watches.
    typedef enum logic {
        PATH_NEG = 1'b0,
        PATH_POS = 1'b1
    } path_e;
endpackage

// File: rtl/phc_delay_line.sv
// Sampled-bit delay: a shift register of local polarity samples with a
// selectable tap, plus a fill counter that marks the tap as meaningful.
module phc_delay_line #(
    parameter int DLY_MAX = 200,
    parameter int DLY_W   = $clog2(DLY_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             flush,
    input  logic [DLY_W-1:0] dly,
    input  logic             din,
    output logic             dout,
    output logic             valid
);
    typedef struct packed {
        logic [DLY_MAX-1:0] hist;
        logic [DLY_W-1:0]   fill;
    } dl_state_t;

    dl_state_t st_d, st_q;
    logic [DLY_W-1:0] tap;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.hist = '0;
            st_d.fill = '0;
        end else if (tick) begin
            st_d.hist = {st_q.hist[DLY_MAX-2:0], din};
            if (st_q.fill < DLY_W'(DLY_MAX)) begin
                st_d.fill = st_q.fill + 1'b1;
            end
        end
    end

    // Tap dly-1 of the pre-shift history holds the sample from dly ticks ago.
    always_comb begin
        tap   = dly - 1'b1;
        dout  = st_q.hist[tap];
        valid = (st_q.fill >= dly);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/phc_coinc_timer.sv
// Integrating coincidence timer for one half-cycle path.
module phc_coinc_timer #(
    parameter phc_pkg::path_e PATH   = phc_pkg::PATH_POS,
    parameter int             PICKUP = 40,
    parameter int             CNT_W  = $clog2(PICKUP + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic flush,
    input  logic valid,
    input  logic loc_dly,
    input  logic rcv,
    output logic hit
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tm_state_t;

    tm_state_t st_d, st_q;
    logic      gate;

    generate
        if (PATH == phc_pkg::PATH_POS) begin : g_pos
            assign gate = loc_dly & rcv;
        end else begin : g_neg
            assign gate = ~loc_dly & ~rcv;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (valid && gate) begin
                if (st_q.cnt != CNT_W'(PICKUP)) begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else begin
                st_d.cnt = '0;
            end
        end
    end

    assign hit = (st_q.cnt == CNT_W'(PICKUP));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sqwave_phase_cmp.sv
// One comparison instance: delayed local square versus received square,
// two half-cycle timers and a latched trip request.
module sqwave_phase_cmp #(
    parameter int DLY_MIN = 20,
    parameter int DLY_MAX = 200,
    parameter int PICKUP  = 40,
    localparam int DLY_W  = $clog2(DLY_MAX + 1),
    localparam int CNT_W  = $clog2(PICKUP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             loc_pol,
    input  logic             rcv_pol,
    input  logic [DLY_W-1:0] dly_set,
    input  logic             enable,
    output logic             coinc_pos,
    output logic             coinc_neg,
    output logic             trip
);
    typedef struct packed {
        logic [DLY_W-1:0] dly;
        logic             trip;
    } top_state_t;

    top_state_t       st_d, st_q;
    logic [DLY_W-1:0] dly_clamped;
    logic             flush;
    logic             loc_dly;
    logic             dly_valid;
    logic [1:0]       hit;

    always_comb begin
        if (dly_set < DLY_W'(DLY_MIN)) begin
            dly_clamped = DLY_W'(DLY_MIN);
        end else if (dly_set > DLY_W'(DLY_MAX)) begin
            dly_clamped = DLY_W'(DLY_MAX);
        end else begin
            dly_clamped = dly_set;
        end
        flush = (dly_clamped != st_q.dly);
    end

    phc_delay_line #(
        .DLY_MAX(DLY_MAX),
        .DLY_W  (DLY_W)
    ) u_dly (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .flush(flush),
        .dly  (st_q.dly),
        .din  (loc_pol),
        .dout (loc_dly),
        .valid(dly_valid)
    );

    for (genvar g = 0; g < 2; g++) begin : g_path
        phc_coinc_timer #(
            .PATH  (phc_pkg::path_e'(g)),
            .PICKUP(PICKUP),
            .CNT_W (CNT_W)
        ) u_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .flush  (flush),
            .valid  (dly_valid),
            .loc_dly(loc_dly),
            .rcv    (rcv_pol),
            .hit    (hit[g])
        );
    end

    assign coinc_neg = hit[phc_pkg::PATH_NEG];
    assign coinc_pos = hit[phc_pkg::PATH_POS];

    always_comb begin
        st_d      = st_q;
        st_d.dly  = dly_clamped;
        st_d.trip = enable & (st_q.trip | coinc_pos | coinc_neg);
    end

    assign trip = st_q.trip;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.dly  <= DLY_W'(DLY_MIN);
            st_q.trip <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/phc_cmp_checker.sv
module phc_cmp_checker (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic enable,
    input logic flush,
    input logic coinc_pos,
    input logic coinc_neg,
    input logic trip
);
    // R3 / R4: flags move only on a tick or a flush
    a_r3_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !flush) |=> ($stable(coinc_pos) && $stable(coinc_neg)));

    // R4: the two half-cycle paths never report together
    a_r4_paths_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(coinc_pos && coinc_neg));

    // R5: no trip without a coincidence flag
    a_r5_trip_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!trip && !coinc_pos && !coinc_neg) |=> !trip);

    // R6: latched while enabled
    a_r6_trip_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (trip && enable) |=> trip);

    // R6: dropped once enable is low
    a_r6_trip_release: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !trip);

    // R7: a flush clears both timers
    a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!coinc_pos && !coinc_neg));
endmodule

bind sqwave_phase_cmp phc_cmp_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .enable   (enable),
    .flush    (flush),
    .coinc_pos(coinc_pos),
    .coinc_neg(coinc_neg),
    .trip     (trip)
);

// File: tb/tb_sqwave_phase_cmp.sv
module tb_sqwave_phase_cmp;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick;
    logic       loc_pol;
    logic       rcv_pol;
    logic [7:0] dly_set;
    logic       enable;
    logic       coinc_pos;
    logic       coinc_neg;
    logic       trip;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #4ns clk = ~clk;

    sqwave_phase_cmp dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .loc_pol  (loc_pol),
        .rcv_pol  (rcv_pol),
        .dly_set  (dly_set),
        .enable   (enable),
        .coinc_pos(coinc_pos),
        .coinc_neg(coinc_neg),
        .trip     (trip)
    );

    typedef struct packed {
        int dly;   // value written to dly_set
        int eff;   // effective delay after clamp
        int per;   // period in ticks
        int hi;    // high ticks per period
        int off;   // extra lag of received wave
        bit exp;   // expected trip
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{40,  40,  200, 100, 0,   1'b1},  // in phase, 50 %
        '{40,  40,  200, 100, 100, 1'b0},  // anti-phase
        '{200, 200, 200, 60,  0,   1'b1},  // short duty, max delay
        '{20,  20,  200, 140, 0,   1'b1},  // long duty, min delay
        '{100, 100, 200, 100, 70,  1'b0},  // 30-tick overlaps
        '{100, 100, 200, 100, 50,  1'b1},  // 50-tick overlaps
        '{20,  20,  166, 83,  83,  1'b0},  // anti-phase, other period
        '{60,  60,  200, 30,  100, 1'b1},  // only negative path overlaps
        '{5,   20,  200, 100, 0,   1'b1}   // clamped setting
    };

    function automatic bit sq(int i, int per, int hi);
        int m;
        m = i % per;
        if (m < 0) m += per;
        return (m < hi);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_tick(input logic l, input logic r);
        @(negedge clk);
        loc_pol = l;
        rcv_pol = r;
        tick    = 1'b1;
        @(negedge clk);
        tick    = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        tick  = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic set_dly(input int v);
        @(negedge clk);
        dly_set = 8'(v);
        repeat (2) @(negedge clk);
    endtask

    // Holds both bits constant for n ticks; returns the first tick index
    // (1-based) after which either flag is high, 0 if none.
    task automatic run_const(input logic l, input logic r, input int n, output int first);
        first = 0;
        for (int i = 1; i <= n; i++) begin
            do_tick(l, r);
            if (first == 0 && (coinc_pos || coinc_neg)) first = i;
        end
    endtask

    // Local pulse of w ticks starting at tick 50, received bit held at 1.
    task automatic run_pulse(input int w, output int first, output int width);
        first = 0;
        width = 0;
        for (int i = 1; i <= 200; i++) begin
            do_tick((i >= 50) && (i < 50 + w), 1'b1);
            if (coinc_pos) begin
                width++;
                if (first == 0) first = i;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL timeout all-requirements actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int first;
        int width;
        bit any;
        rst_n   = 1'b0;
        tick    = 1'b0;
        loc_pol = 1'b0;
        rcv_pol = 1'b0;
        dly_set = 8'd20;
        enable  = 1'b1;

        // R9: reset state
        do_reset();
        chk(coinc_pos == 1'b0, "R9 coinc_pos after reset", coinc_pos, 0);
        chk(coinc_neg == 1'b0, "R9 coinc_neg after reset", coinc_neg, 0);
        chk(trip == 1'b0, "R9 trip after reset", trip, 0);

        // R3 / R7: positive pickup at tick D+40 after a flush (D = 20)
        run_const(1'b1, 1'b1, 70, first);
        chk(first == 60, "R3 R7 positive pickup tick", first, 60);
        chk(coinc_neg == 1'b0, "R4 negative idle on positive match", coinc_neg, 0);
        @(negedge clk);
        chk(trip == 1'b1, "R5 trip after positive flag", trip, 1);

        // R7: setting change flushes; R6: trip stays latched
        set_dly(30);
        chk(coinc_pos == 1'b0, "R7 flag cleared by setting change", coinc_pos, 0);
        chk(trip == 1'b1, "R6 trip held across setting change", trip, 1);
        run_const(1'b1, 1'b1, 80, first);
        chk(first == 70, "R7 refill pickup tick with D=30", first, 70);

        // R6: enable low drops trip
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk(trip == 1'b0, "R6 trip dropped by enable", trip, 0);

        // R4: negative path, received inverted; R5: no trip while disabled
        set_dly(25);
        run_const(1'b0, 1'b0, 70, first);
        chk(first == 65, "R4 negative pickup tick", first, 65);
        chk(coinc_neg == 1'b1 && coinc_pos == 1'b0, "R4 only negative flag", coinc_neg, 1);
        @(negedge clk);
        chk(trip == 1'b0, "R5 no trip while disabled", trip, 0);
        enable = 1'b1;
        repeat (2) @(negedge clk);
        chk(trip == 1'b1, "R5 trip once enabled with flag", trip, 1);

        // R8: clamp limits
        set_dly(5);
        run_const(1'b1, 1'b1, 70, first);
        chk(first == 60, "R8 low clamp acts as 20", first, 60);
        set_dly(250);
        run_const(1'b1, 1'b1, 250, first);
        chk(first == 240, "R8 high clamp acts as 200", first, 240);

        // R1 / R2: exact delay and preserved pulse width
        set_dly(20);
        run_pulse(40, first, width);
        chk(first == 109, "R1 delayed pulse end tick", first, 109);
        chk(width == 1, "R2 40-tick pulse flag width", width, 1);
        set_dly(33);
        run_pulse(39, first, width);
        chk(width == 0, "R2 39-tick pulse gives no flag", width, 0);

        // R9: asynchronous reset clears a latched trip
        set_dly(20);
        run_const(1'b1, 1'b1, 62, first);
        @(negedge clk);
        chk(trip == 1'b1, "R5 trip before reset", trip, 1);
        rst_n = 1'b0;
        #1ns;
        chk(trip == 1'b0 && coinc_pos == 1'b0, "R9 reset clears trip and flags", trip, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table: square waves with phase offsets and duty ratios
        for (int v = 0; v < NVEC; v++) begin
            dly_set = 8'(VECS[v].dly);
            enable  = 1'b1;
            do_reset();
            any = 1'b0;
            for (int i = 0; i <= 3 * VECS[v].per + VECS[v].eff; i++) begin
                do_tick(sq(i, VECS[v].per, VECS[v].hi),
                        sq(i - VECS[v].eff - VECS[v].off, VECS[v].per, VECS[v].hi));
                if (coinc_pos || coinc_neg) any = 1'b1;
            end
            @(negedge clk);
            if (VECS[v].exp) begin
                chk(trip == 1'b1, $sformatf("R5 vector %0d trips", v), trip, 1);
            end else begin
                chk(trip == 1'b0 && !any, $sformatf("R10 vector %0d no trip", v), trip, 0);
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule